// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the entry into an interrupt service routine for a small 8-bit processor with a 16-bit program counter and a 16-bit stack pointer. The execution core reports instruction boundaries and a few retired instructions: halt, enable interrupts, disable interrupts, select interrupt mode, and end of non-maskable service. The sequencer owns the halted flag, the maskable-enable flag, the non-maskable-in-service flag and the 2-bit interrupt mode.

At a boundary it picks at most one request. The non-maskable request wins over a maskable one. For every kind except mode 0, it pushes the return address as two byte writes. In mode 2 it also fetches a 16-bit vector. It then presents the new PC, the new SP and the cycle charge for one clock. In mode 0 it pushes nothing and instead passes the data-bus byte to the instruction decoder as an opcode.

A halted core resumes at the instruction after the halt. An enable-interrupts instruction that retires while a maskable request is waiting raises a strobe. The strobe tells the core to end its run after one more instruction.

Top module: `irq_entry_seq`

FSM states: IDLE (wait for a boundary), PUSH_HI (write the high PC byte), PUSH_LO (write the low PC byte), VEC_RD (wait for the vector word), DONE (present results).

Transitions:
- IDLE→PUSH_HI when a request is taken in NMI, mode 1 or mode 2.
- IDLE→DONE when a request is taken in mode 0.
- PUSH_HI→PUSH_LO always.
- PUSH_LO→VEC_RD in mode 2.
- PUSH_LO→DONE otherwise.
- VEC_RD→DONE on read acknowledge.
- DONE→IDLE always.

## Requirements
- R1: After reset the block is idle, with no write, no read and no done. The enable flag, halted flag, in-service flag and mode (`mode_o` = 0) are all clear.
- R2: A non-maskable request taken at a boundary sets the in-service flag and sets SP to SP−2. It loads PC with NMI_VEC (0x0066) and charges CYC_NMI (11) cycles.
- R3: While the in-service flag is set, a non-maskable request causes no write and no done. A pulse on `nmi_done_i` clears the flag, after which a request is taken again.
- R4: `halt_exec_i` sets `halted_o`. When any request is taken while halted, the pushed and handed-over PC is `pc_i`+1 (modulo 2^16) and `halted_o` clears.
- R5: A push is two byte writes on consecutive cycles. The first writes PC[15:8] at SP−1 and the second writes PC[7:0] at SP−2, with addresses modulo 2^16.
- R6: A maskable request is taken only while `iff_o` is 1, and taking it clears `iff_o`. `ei_exec_i` sets the flag and `di_exec_i` clears it.
- R7: In mode 1 (`mode_o` = 1) a taken maskable request pushes PC, loads PC with IM1_VEC (0x0038) and charges CYC_IM1 (11).
- R8: In mode 2 (`mode_o` = 2), after the push, `rd_req_o` is held with address {`i_reg_i`, `bus_byte_i`} until `rd_ack_i`. The new PC is `rd_data_i`, and the charge is CYC_IM2 (19).
- R9: In mode 0 (`mode_o` = 0) there is no write and no read, and SP is unchanged. `decode_o` pulses with `done_o`, `opcode_o` equals the bus byte, the charge is 0, and PC is `pc_i` (+1 if halted).
- R10: A boundary in the same cycle as `ei_exec_i` cannot take a maskable request when the flag was clear; the next boundary can. `cut_budget_o` is 1 exactly when `ei_exec_i`, `int_req_i`, a clear enable flag and a clear in-service flag coincide.
- R11: When both requests arrive at one boundary, the non-maskable one is taken and `iff_o` is left unchanged.
- R12: Requests are sampled only when `boundary_i` is 1 and the block is idle. Requests raised without a boundary, or while busy, start nothing.
- R13: `im_set_i` with `im_val_i` of 0, 1 or 2 sets the mode. The value 3 leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boundary_i | input | 1 | Instruction boundary, requests sampled |
| nmi_req_i | input | 1 | Non-maskable request |
| int_req_i | input | 1 | Maskable request |
| bus_byte_i | input | 8 | Byte on the data bus at acknowledge |
| i_reg_i | input | 8 | Vector table page register |
| pc_i | input | 16 | Core PC at the boundary |
| sp_i | input | 16 | Core SP at the boundary |
| halt_exec_i | input | 1 | Halt instruction retired |
| ei_exec_i | input | 1 | Enable-interrupts instruction retired |
| di_exec_i | input | 1 | Disable-interrupts instruction retired |
| im_set_i | input | 1 | Mode-select instruction retired |
| im_val_i | input | 2 | Requested mode |
| nmi_done_i | input | 1 | Non-maskable service finished |
| mem_wr_o | output | 1 | Byte write strobe |
| mem_addr_o | output | 16 | Write address |
| mem_wdata_o | output | 8 | Write data |
| rd_req_o | output | 1 | Vector read request |
| rd_addr_o | output | 16 | Vector read address |
| rd_ack_i | input | 1 | Vector read acknowledge |
| rd_data_i | input | 16 | Vector word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Results valid for one cycle |
| pc_o | output | 16 | New PC |
| sp_o | output | 16 | New SP |
| cycles_o | output | CW | Cycle charge |
| decode_o | output | 1 | Mode-0 opcode handoff |
| opcode_o | output | 8 | Opcode for the decoder |
| cut_budget_o | output | 1 | End the run after one more instruction |
| halted_o | output | 1 | Halted state |
| iff_o | output | 1 | Maskable enable flag |
| nmi_active_o | output | 1 | Non-maskable in service |
| mode_o | output | 2 | Interrupt mode |

## Verification
The bench builds the block with its default parameters: CW = 8, vectors 0x0066 and 0x0038, and charges 11, 11 and 19. These defaults make the exact entry addresses and charges directly comparable. The 16-bit address width lets the bench push from SP = 0x0000 and resume from a halt at PC = 0xFFFF, so both wrap-arounds of R4 and R5 are exercised. A slow vector acknowledge of four cycles exposes the hold behaviour of R8.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_HI,
        S_PUSH_LO,
        S_VEC_RD,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        K_NMI,
        K_MODE0,
        K_MODE1,
        K_MODE2
    } entry_kind_t;

    localparam logic [MODE_W-1:0] MODE_ZERO = 2'd0;
    localparam logic [MODE_W-1:0] MODE_ONE  = 2'd1;
    localparam logic [MODE_W-1:0] MODE_TWO  = 2'd2;
    localparam logic [MODE_W-1:0] MODE_BAD  = 2'd3;
endpackage

// File: rtl/irq_accept.sv
module irq_accept
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              idle_i,
    input  logic              nmi_req_i,
    input  logic              int_req_i,
    input  logic              halt_exec_i,
    input  logic              ei_exec_i,
    input  logic              di_exec_i,
    input  logic              im_set_i,
    input  logic [MODE_W-1:0] im_val_i,
    input  logic              nmi_done_i,
    output logic              take_nmi_o,
    output logic              take_int_o,
    output logic              cut_budget_o,
    output logic              iff_o,
    output logic              nmi_active_o,
    output logic              halted_o,
    output logic [MODE_W-1:0] mode_o
);
    logic              iff_q;
    logic              nmi_act_q;
    logic              halted_q;
    logic [MODE_W-1:0] mode_q;
    logic              sample_ok;
    logic              take_any;

    // Requests count only at a boundary with the sequencer at rest (R12)
    assign sample_ok  = boundary_i && idle_i;
    assign take_nmi_o = sample_ok && nmi_req_i && !nmi_act_q;
    assign take_int_o = sample_ok && int_req_i && iff_q && !take_nmi_o;
    assign take_any   = take_nmi_o || take_int_o;

    // Early-end strobe for the core's cycle budget (R10)
    assign cut_budget_o = ei_exec_i && !iff_q && int_req_i && !nmi_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iff_q <= 1'b0;
        end else if (take_int_o) begin
            iff_q <= 1'b0;
        end else if (di_exec_i) begin
            iff_q <= 1'b0;
        end else if (ei_exec_i) begin
            iff_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_act_q <= 1'b0;
        end else if (take_nmi_o) begin
            nmi_act_q <= 1'b1;
        end else if (nmi_done_i) begin
            nmi_act_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
        end else if (take_any) begin
            halted_q <= 1'b0;
        end else if (halt_exec_i) begin
            halted_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_ZERO;
        end else if (im_set_i && (im_val_i != MODE_BAD)) begin
            mode_q <= im_val_i;
        end
    end

    assign iff_o        = iff_q;
    assign nmi_active_o = nmi_act_q;
    assign halted_o     = halted_q;
    assign mode_o       = mode_q;

    a_r6_take_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        take_int_o |=> !iff_q);

    a_r3_service_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_act_q && !nmi_done_i && !take_nmi_o) |=> nmi_act_q);

    a_r4_take_leaves_halt: assert property (@(posedge clk) disable iff (!rst_n)
        take_any |=> !halted_q);

    a_r13_bad_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (im_set_i && im_val_i == MODE_BAD) |=> $stable(mode_q));
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int               CW      = 8,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
    parameter logic [ADDR_W-1:0] IM1_VEC = 16'h0038,
    parameter int               CYC_NMI = 11,
    parameter int               CYC_IM1 = 11,
    parameter int               CYC_IM2 = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_nmi_i,
    input  logic              take_int_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              halted_i,
    input  addr_t             pc_i,
    input  addr_t             sp_i,
    input  byte_t             i_reg_i,
    input  byte_t             bus_byte_i,
    input  logic              rd_ack_i,
    input  addr_t             rd_data_i,
    output logic              mem_wr_o,
    output addr_t             mem_addr_o,
    output byte_t             mem_wdata_o,
    output logic              rd_req_o,
    output addr_t             rd_addr_o,
    output logic              busy_o,
    output logic              done_o,
    output addr_t             pc_o,
    output addr_t             sp_o,
    output logic [CW-1:0]     cycles_o,
    output logic              decode_o,
    output byte_t             opcode_o
);
    localparam addr_t PUSH_DEPTH = addr_t'(ADDR_W / BYTE_W);
    localparam addr_t ONE_A      = addr_t'(1);

    seq_state_t  state_q, state_d;
    entry_kind_t kind_q, kind_d;
    addr_t       ret_q, sp_q, tgt_q, ptr_q;
    logic [CW-1:0] cyc_q, cyc_d;
    byte_t       op_q;
    logic        start;
    addr_t       resume_pc;

    assign start     = take_nmi_i || take_int_i;
    assign resume_pc = pc_i + addr_t'(halted_i);

    // Entry kind from the winning request and the current mode
    always_comb begin
        if (take_nmi_i) begin
            kind_d = K_NMI;
        end else begin
            unique case (mode_i)
                MODE_ONE: kind_d = K_MODE1;
                MODE_TWO: kind_d = K_MODE2;
                default:  kind_d = K_MODE0;
            endcase
        end
    end

    always_comb begin
        unique case (kind_d)
            K_NMI:   cyc_d = CW'(CYC_NMI);
            K_MODE1: cyc_d = CW'(CYC_IM1);
            K_MODE2: cyc_d = CW'(CYC_IM2);
            default: cyc_d = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = (kind_d == K_MODE0) ? S_DONE : S_PUSH_HI;
                end
            end
            S_PUSH_HI: state_d = S_PUSH_LO;
            S_PUSH_LO: state_d = (kind_q == K_MODE2) ? S_VEC_RD : S_DONE;
            S_VEC_RD:  if (rd_ack_i) state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Entry context captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_MODE0;
            ret_q  <= '0;
            sp_q   <= '0;
            tgt_q  <= '0;
            ptr_q  <= '0;
            cyc_q  <= '0;
            op_q   <= '0;
        end else if (state_q == S_IDLE && start) begin
            kind_q <= kind_d;
            ret_q  <= resume_pc;
            sp_q   <= (kind_d == K_MODE0) ? sp_i : sp_i - PUSH_DEPTH;
            ptr_q  <= {i_reg_i, bus_byte_i};
            cyc_q  <= cyc_d;
            op_q   <= bus_byte_i;
            unique case (kind_d)
                K_NMI:   tgt_q <= NMI_VEC;
                K_MODE1: tgt_q <= IM1_VEC;
                K_MODE0: tgt_q <= resume_pc;
                default: tgt_q <= '0;
            endcase
        end else if (state_q == S_VEC_RD && rd_ack_i) begin
            tgt_q <= rd_data_i;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mem_wr_o    = 1'b0;
        mem_addr_o  = sp_q;
        mem_wdata_o = ret_q[BYTE_W-1:0];
        rd_req_o    = 1'b0;
        done_o      = 1'b0;
        decode_o    = 1'b0;
        unique case (state_q)
            S_PUSH_HI: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = sp_q + ONE_A;
                mem_wdata_o = ret_q[ADDR_W-1:ADDR_W-BYTE_W];
            end
            S_PUSH_LO: begin
                mem_wr_o    = 1'b1;
            end
            S_VEC_RD: begin
                rd_req_o    = 1'b1;
            end
            S_DONE: begin
                done_o      = 1'b1;
                decode_o    = (kind_q == K_MODE0);
            end
            default: begin
            end
        endcase
    end

    assign busy_o    = (state_q != S_IDLE);
    assign rd_addr_o = ptr_q;
    assign pc_o      = tgt_q;
    assign sp_o      = sp_q;
    assign cycles_o  = cyc_q;
    assign opcode_o  = op_q;

    a_r5_low_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && state_q == S_PUSH_HI) |=> (mem_wr_o && mem_addr_o == $past(mem_addr_o) - ONE_A));

    a_r8_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    a_r9_handoff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        decode_o |-> (done_o && !mem_wr_o && !rd_req_o));

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int               CW      = 8,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
    parameter logic [ADDR_W-1:0] IM1_VEC = 16'h0038,
    parameter int               CYC_NMI = 11,
    parameter int               CYC_IM1 = 11,
    parameter int               CYC_IM2 = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              nmi_req_i,
    input  logic              int_req_i,
    input  logic [BYTE_W-1:0] bus_byte_i,
    input  logic [BYTE_W-1:0] i_reg_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic              halt_exec_i,
    input  logic              ei_exec_i,
    input  logic              di_exec_i,
    input  logic              im_set_i,
    input  logic [MODE_W-1:0] im_val_i,
    input  logic              nmi_done_i,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [ADDR_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [CW-1:0]     cycles_o,
    output logic              decode_o,
    output logic [BYTE_W-1:0] opcode_o,
    output logic              cut_budget_o,
    output logic              halted_o,
    output logic              iff_o,
    output logic              nmi_active_o,
    output logic [MODE_W-1:0] mode_o
);
    logic take_nmi, take_int;

    irq_accept u_accept (
        .clk          (clk),
        .rst_n        (rst_n),
        .boundary_i   (boundary_i),
        .idle_i       (!busy_o),
        .nmi_req_i    (nmi_req_i),
        .int_req_i    (int_req_i),
        .halt_exec_i  (halt_exec_i),
        .ei_exec_i    (ei_exec_i),
        .di_exec_i    (di_exec_i),
        .im_set_i     (im_set_i),
        .im_val_i     (im_val_i),
        .nmi_done_i   (nmi_done_i),
        .take_nmi_o   (take_nmi),
        .take_int_o   (take_int),
        .cut_budget_o (cut_budget_o),
        .iff_o        (iff_o),
        .nmi_active_o (nmi_active_o),
        .halted_o     (halted_o),
        .mode_o       (mode_o)
    );

    irq_seq_fsm #(
        .CW      (CW),
        .NMI_VEC (NMI_VEC),
        .IM1_VEC (IM1_VEC),
        .CYC_NMI (CYC_NMI),
        .CYC_IM1 (CYC_IM1),
        .CYC_IM2 (CYC_IM2)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_nmi_i  (take_nmi),
        .take_int_i  (take_int),
        .mode_i      (mode_o),
        .halted_i    (halted_o),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .i_reg_i     (i_reg_i),
        .bus_byte_i  (bus_byte_i),
        .rd_ack_i    (rd_ack_i),
        .rd_data_i   (rd_data_i),
        .mem_wr_o    (mem_wr_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .rd_req_o    (rd_req_o),
        .rd_addr_o   (rd_addr_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .pc_o        (pc_o),
        .sp_o        (sp_o),
        .cycles_o    (cycles_o),
        .decode_o    (decode_o),
        .opcode_o    (opcode_o)
    );

    a_r12_no_take_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(take_nmi || take_int));

    a_r11_nmi_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (take_nmi && !di_exec_i && !ei_exec_i) |=> (iff_o == $past(iff_o)));
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
    localparam int CW = 8;

    typedef struct packed {
        logic        nmi;
        logic        halt;
        logic [1:0]  mode;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [7:0]  ireg;
        logic [7:0]  bus;
        logic [15:0] rd;
        logic [15:0] exp_pc;
        logic [7:0]  exp_cyc;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 2'd1, 16'h1234, 16'h8000, 8'h00, 8'h00, 16'h0000, 16'h0066, 8'd11},
        '{1'b0, 1'b1, 2'd1, 16'h0100, 16'h0000, 8'h00, 8'h00, 16'h0000, 16'h0038, 8'd11},
        '{1'b0, 1'b0, 2'd2, 16'hABCD, 16'h4000, 8'h20, 8'h10, 16'hBEEF, 16'hBEEF, 8'd19},
        '{1'b0, 1'b0, 2'd0, 16'h0200, 16'h5000, 8'h00, 8'hFF, 16'h0000, 16'h0200, 8'd0},
        '{1'b0, 1'b1, 2'd0, 16'h0300, 16'h6000, 8'h00, 8'hC7, 16'h0000, 16'h0301, 8'd0},
        '{1'b1, 1'b1, 2'd2, 16'hFFFF, 16'h1000, 8'h00, 8'h00, 16'h0000, 16'h0066, 8'd11}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, boundary_i, nmi_req_i, int_req_i, halt_exec_i, ei_exec_i, di_exec_i;
    logic im_set_i, nmi_done_i, rd_ack_i;
    logic [1:0]  im_val_i;
    logic [7:0]  bus_byte_i, i_reg_i;
    logic [15:0] pc_i, sp_i, rd_data_i;
    logic mem_wr_o, rd_req_o, busy_o, done_o, decode_o, cut_budget_o, halted_o, iff_o, nmi_active_o;
    logic [15:0] mem_addr_o, rd_addr_o, pc_o, sp_o;
    logic [7:0]  mem_wdata_o, opcode_o;
    logic [CW-1:0] cycles_o;
    logic [1:0]  mode_o;

    irq_entry_seq #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .nmi_req_i(nmi_req_i),
        .int_req_i(int_req_i), .bus_byte_i(bus_byte_i), .i_reg_i(i_reg_i), .pc_i(pc_i),
        .sp_i(sp_i), .halt_exec_i(halt_exec_i), .ei_exec_i(ei_exec_i), .di_exec_i(di_exec_i),
        .im_set_i(im_set_i), .im_val_i(im_val_i), .nmi_done_i(nmi_done_i),
        .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .sp_o(sp_o), .cycles_o(cycles_o),
        .decode_o(decode_o), .opcode_o(opcode_o), .cut_budget_o(cut_budget_o),
        .halted_o(halted_o), .iff_o(iff_o), .nmi_active_o(nmi_active_o), .mode_o(mode_o)
    );

    int  tests = 0;
    int  fails = 0;
    bit  finished = 0;

    int          nwr, rd_cnt, ack_delay, busy_seen, o_cyc;
    logic [15:0] wa [4];
    logic [7:0]  wd [4];
    bit          seen_done, o_dec;
    logic [15:0] o_pc, o_sp, o_rda, rd_word;
    logic [7:0]  o_op;

    task automatic chk(string tag, string what, int got, int exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic cyc(bit b, bit nmi, bit irq, bit hlt, bit ei, bit di, bit ims, logic [1:0] imv, bit nd);
        @(negedge clk);
        boundary_i = b; nmi_req_i = nmi; int_req_i = irq; halt_exec_i = hlt;
        ei_exec_i = ei; di_exec_i = di; im_set_i = ims; im_val_i = imv; nmi_done_i = nd;
    endtask

    task automatic quiet();
        cyc(0, 0, 0, 0, 0, 0, 0, 2'd0, 0);
    endtask

    task automatic observe(int n);
        nwr = 0; seen_done = 0; rd_cnt = 0; o_dec = 0; busy_seen = 0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            #1;
            if (busy_o) busy_seen++;
            if (mem_wr_o) begin
                if (nwr < 4) begin wa[nwr] = mem_addr_o; wd[nwr] = mem_wdata_o; end
                nwr++;
            end
            if (rd_req_o) begin rd_cnt++; o_rda = rd_addr_o; end
            rd_ack_i  = rd_req_o && (rd_cnt > ack_delay);
            rd_data_i = rd_word;
            if (done_o) begin
                seen_done = 1; o_pc = pc_o; o_sp = sp_o; o_cyc = int'(cycles_o);
                o_dec = decode_o; o_op = opcode_o;
            end
        end
        rd_ack_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        boundary_i = 0; nmi_req_i = 0; int_req_i = 0; halt_exec_i = 0; ei_exec_i = 0;
        di_exec_i = 0; im_set_i = 0; im_val_i = 0; nmi_done_i = 0; rd_ack_i = 0;
        rd_data_i = 0; bus_byte_i = 0; i_reg_i = 0; pc_i = 0; sp_i = 0;
        ack_delay = 0; rd_word = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        #1;
        chk("R1", "busy", busy_o, 0);
        chk("R1", "iff", iff_o, 0);
        chk("R1", "mode", mode_o, 0);
        chk("R1", "halted", halted_o, 0);
        chk("R1", "nmi_active", nmi_active_o, 0);
        chk("R1", "wr/rd/done", {mem_wr_o, rd_req_o, done_o}, 0);

        // Table of entries
        foreach (VECS[k]) begin
            vec_t v;
            string tag;
            logic [15:0] pushed, exp_sp;
            bit m0;
            v = VECS[k];
            m0 = !v.nmi && v.mode == 2'd0;
            tag = v.nmi ? "R2" : (v.mode == 2'd1 ? "R7" : (v.mode == 2'd2 ? "R8" : "R9"));
            pushed = v.pc + 16'(v.halt);
            exp_sp = m0 ? v.sp : v.sp - 16'd2;
            do_reset();
            rd_word = v.rd;
            cyc(0, 0, 0, 0, 0, 0, 1, v.mode, 0);
            if (v.halt) cyc(0, 0, 0, 1, 0, 0, 0, 2'd0, 0);
            if (!v.nmi) cyc(0, 0, 0, 0, 1, 0, 0, 2'd0, 0);
            quiet();
            #1;
            chk("R4", "halted before", halted_o, v.halt);
            bus_byte_i = v.bus; i_reg_i = v.ireg; pc_i = v.pc; sp_i = v.sp;
            cyc(1, v.nmi, !v.nmi, 0, 0, 0, 0, 2'd0, 0);
            quiet();
            observe(10);
            chk(tag, "done", seen_done, 1);
            chk(v.halt ? "R4" : tag, "pc", int'(o_pc), int'(v.exp_pc));
            chk(tag, "sp", int'(o_sp), int'(exp_sp));
            chk(tag, "cycles", o_cyc, int'(v.exp_cyc));
            chk(m0 ? "R9" : "R5", "writes", nwr, m0 ? 0 : 2);
            if (!m0) begin
                chk("R5", "hi addr", int'(wa[0]), int'(16'(v.sp - 16'd1)));
                chk("R5", "hi data", int'(wd[0]), int'(pushed[15:8]));
                chk("R5", "lo addr", int'(wa[1]), int'(16'(v.sp - 16'd2)));
                chk("R5", "lo data", int'(wd[1]), int'(pushed[7:0]));
            end
            if (!v.nmi && v.mode == 2'd2) chk("R8", "rd addr", int'(o_rda), int'({v.ireg, v.bus}));
            chk(tag, "reads", rd_cnt, (!v.nmi && v.mode == 2'd2) ? 1 : 0);
            chk("R9", "decode", o_dec, m0);
            if (m0) chk("R9", "opcode", int'(o_op), int'(v.bus));
            chk("R4", "halted after", halted_o, 0);
            if (v.nmi) chk("R2", "nmi_active", nmi_active_o, 1);
            else chk("R6", "iff cleared", iff_o, 0);
        end

        // R3: second NMI ignored while in service, re-armed by done pulse
        do_reset();
        pc_i = 16'h1111; sp_i = 16'h2000;
        cyc(1, 1, 0, 0, 0, 0, 0, 2'd0, 0); quiet(); observe(8);
        chk("R3", "first nmi", seen_done, 1);
        cyc(1, 1, 0, 0, 0, 0, 0, 2'd0, 0); quiet(); observe(8);
        chk("R3", "blocked writes", nwr, 0);
        chk("R3", "blocked done", seen_done, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 2'd0, 1); quiet(); #1;
        chk("R3", "flag cleared", nmi_active_o, 0);
        cyc(1, 1, 0, 0, 0, 0, 0, 2'd0, 0); quiet(); observe(8);
        chk("R3", "re-armed writes", nwr, 2);

        // R6: masked request ignored; disable after enable
        do_reset();
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, 0);
        cyc(1, 0, 1, 0, 0, 0, 0, 2'd0, 0); quiet(); observe(6);
        chk("R6", "masked busy", busy_seen, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 2'd0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 2'd0, 0); quiet(); #1;
        chk("R6", "di clears", iff_o, 0);
        cyc(1, 0, 1, 0, 0, 0, 0, 2'd0, 0); quiet(); observe(6);
        chk("R6", "after di", nwr, 0);

        // R10: enable delay and budget cut
        do_reset();
        pc_i = 16'h0777; sp_i = 16'h9000;
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, 0);
        cyc(1, 0, 1, 0, 1, 0, 0, 2'd0, 0); #1;
        chk("R10", "cut strobe", cut_budget_o, 1);
        cyc(0, 0, 1, 0, 0, 0, 0, 2'd0, 0); #1;
        chk("R10", "not taken at ei", busy_o, 0);
        chk("R10", "iff set", iff_o, 1);
        cyc(1, 0, 1, 0, 1, 0, 0, 2'd0, 0); #1;
        chk("R10", "no cut when enabled", cut_budget_o, 0);
        quiet(); observe(8);
        chk("R10", "taken next", int'(o_pc), 16'h0038);
        do_reset();
        cyc(1, 1, 0, 0, 0, 0, 0, 2'd0, 0); quiet(); observe(8);
        cyc(0, 0, 1, 0, 1, 0, 0, 2'd0, 0); #1;
        chk("R10", "no cut in nmi", cut_budget_o, 0);
        quiet();

        // R11: simultaneous requests
        do_reset();
        pc_i = 16'h4000; sp_i = 16'h3000;
        cyc(0, 0, 0, 0, 1, 0, 1, 2'd1, 0); quiet();
        cyc(1, 1, 1, 0, 0, 0, 0, 2'd0, 0); quiet(); observe(8);
        chk("R11", "nmi wins", int'(o_pc), 16'h0066);
        chk("R11", "iff kept", iff_o, 1);
        cyc(1, 0, 1, 0, 0, 0, 0, 2'd0, 0); quiet(); observe(8);
        chk("R11", "maskable later", int'(o_pc), 16'h0038);

        // R12: no boundary, and requests while busy
        do_reset();
        cyc(0, 0, 0, 0, 1, 0, 1, 2'd1, 0);
        cyc(0, 1, 1, 0, 0, 0, 0, 2'd0, 0); quiet(); observe(5);
        chk("R12", "no boundary", busy_seen, 0);
        cyc(1, 1, 0, 0, 0, 0, 0, 2'd0, 0);
        cyc(1, 0, 1, 0, 0, 0, 0, 2'd0, 0);
        cyc(1, 0, 1, 0, 0, 0, 0, 2'd0, 0);
        quiet(); observe(8);
        chk("R12", "only nmi done", int'(o_pc), 16'h0066);
        chk("R12", "no extra writes", nwr, 0);
        chk("R12", "iff untouched", iff_o, 1);

        // R13: illegal mode value ignored
        do_reset();
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd2, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd3, 0); quiet(); #1;
        chk("R13", "mode kept", mode_o, 2);

        // R8: slow vector acknowledge
        do_reset();
        pc_i = 16'h2222; sp_i = 16'h7000; i_reg_i = 8'h44; bus_byte_i = 8'h0E;
        ack_delay = 3; rd_word = 16'h1357;
        cyc(0, 0, 0, 0, 1, 0, 1, 2'd2, 0); quiet();
        cyc(1, 0, 1, 0, 0, 0, 0, 2'd0, 0); quiet(); observe(14);
        chk("R8", "slow pc", int'(o_pc), 16'h1357);
        chk("R8", "req cycles", rd_cnt, 4);
        chk("R8", "slow addr", int'(o_rda), 16'h440E);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule